// File: doc/BRIEF.md
# Temperature Alarm Window Event Generator

The block checks each finished temperature conversion against three programmable limits: a lower and an upper bound that together form an alarm window, and a critical limit above the window. It drives one event pin. Any movement of the temperature into or out of the window is remembered as a window event until software clears it. A reading at or above the critical limit raises an event that only a falling temperature can release.

Software programs the block through a simple write port. Addresses 02h, 03h and 04h hold the upper, lower and critical limits. Address 01h holds a control word with an enable, an event polarity, a self-clearing release bit and a hysteresis code. Samples arrive with a one-cycle conversion-done strobe. Limits and samples are 11-bit two's-complement values in 0.25 °C steps. After any limit is rewritten, and after reset, comparison is suspended for a programmable number of conversions so that a stale reading never drives the pin. The pin is meant to feed an open-drain driver, so a pull-down enable is also provided.

Top module: `temp_event_gen`

## Requirements
- R1: After reset the event is inactive. With the default active-low polarity, event_pin is 1 and event_pull_en is 0.
- R2: A write to 02h loads the upper limit, 03h the lower limit and 04h the critical limit (data bits 10:0). A write to 01h loads the control word: bit 0 enable, bit 1 polarity (1 = active high), bit 2 release, bits 4:3 hysteresis code. A write to any other address changes nothing.
- R3: While enabled, a compared sample whose zone (below, inside, above the window) differs from the previous zone latches a window event, and the event pin goes active.
- R4: Entering the window from below happens at temperature >= lower. Leaving it downward needs temperature < lower - H, where H is 0, 6, 12 or 24 LSB (0, 1.5, 3, 6 °C) for codes 0 to 3.
- R5: A compared sample >= critical makes the event active. It stays active until a sample < critical - H. The release bit has no effect on it.
- R6: Writing the control word with the release bit set clears a latched window event. If a crossing sample is compared on the same clock edge, the new event wins and stays latched.
- R7: After reset, and after every write to 02h, 03h or 04h, the next HOLD conversion strobes (default 1) are not compared. Zone and critical state keep their values.
- R8: With enable at 0 the pin is inactive and crossings are not latched, so setting the enable again does not bring back a crossing that happened while disabled.
- R9: event_pin is high when active if polarity is 1, and low when active if polarity is 0. event_pull_en is always the inverse of event_pin.
- R10: Leaving the zone above the window happens at temperature <= upper, with no hysteresis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 16 | Register write data |
| conv_done | input | 1 | New temperature sample strobe |
| conv_temp | input | 11 | Sample, two's complement, 0.25 °C per LSB |
| event_pin | output | 1 | Event level at the selected polarity |
| event_pull_en | output | 1 | Pull-down enable for an open-drain driver |

## Verification
A release write and a crossing sample can land on the same clock edge, and the two act on the same window-event latch in opposite directions. The bench provokes this by driving a release-bit control write together with a conversion strobe whose sample moves the temperature from above the window back inside it. It expects the pin to stay active. A later release on its own must then clear it. A second overlap is between a limit write and the holdoff: a sample that would cross right after a limit write must leave the pin unchanged, and the next sample must produce the event.

// File: rtl/temp_event_gen.sv
module temp_event_gen #(
  parameter int TW = 11,
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int HOLD = 1,
  parameter logic [AW-1:0] A_CFG = 8'h01,
  parameter logic [AW-1:0] A_UPPER = 8'h02,
  parameter logic [AW-1:0] A_LOWER = 8'h03,
  parameter logic [AW-1:0] A_CRIT = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          conv_done,
  input  logic [TW-1:0] conv_temp,
  output logic          event_pin,
  output logic          event_pull_en
);
  localparam int SW = TW + 2;
  localparam int HCW = (HOLD < 1) ? 1 : $clog2(HOLD + 1);
  localparam logic [1:0] Z_BELOW = 2'd0, Z_INSIDE = 2'd1, Z_ABOVE = 2'd2;

  logic [TW-1:0]  upper_q, lower_q, crit_q;
  logic           en_q, pol_q;
  logic [1:0]     hyst_q, zone_q, zone_nx;
  logic           crit_hit_q, crit_nx, win_evt_q;
  logic [HCW-1:0] hold_q;
  logic signed [SW-1:0] t_s, up_s, lo_s, cr_s, h_s;

  wire cfg_wr  = wr_en && (wr_addr == A_CFG);
  wire win_wr  = wr_en && (wr_addr == A_UPPER || wr_addr == A_LOWER || wr_addr == A_CRIT);
  wire compare = conv_done && (hold_q == '0);

  assign t_s  = SW'(signed'(conv_temp));
  assign up_s = SW'(signed'(upper_q));
  assign lo_s = SW'(signed'(lower_q));
  assign cr_s = SW'(signed'(crit_q));

  always_comb begin
    case (hyst_q)
      2'd0: h_s = SW'(0);
      2'd1: h_s = SW'(6);
      2'd2: h_s = SW'(12);
      default: h_s = SW'(24);
    endcase
  end

  always_comb begin
    if (t_s > up_s)
      zone_nx = Z_ABOVE;
    else if (zone_q == Z_BELOW)
      zone_nx = (t_s >= lo_s) ? Z_INSIDE : Z_BELOW;
    else
      zone_nx = (t_s < lo_s - h_s) ? Z_BELOW : Z_INSIDE;
  end

  assign crit_nx = crit_hit_q ? !(t_s < cr_s - h_s) : (t_s >= cr_s);

  wire crossing = compare && (zone_nx != zone_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      lower_q <= '0;
      crit_q  <= '0;
      en_q    <= 1'b0;
      pol_q   <= 1'b0;
      hyst_q  <= 2'd0;
    end else begin
      if (wr_en && wr_addr == A_UPPER) upper_q <= wr_data[TW-1:0];
      if (wr_en && wr_addr == A_LOWER) lower_q <= wr_data[TW-1:0];
      if (wr_en && wr_addr == A_CRIT)  crit_q  <= wr_data[TW-1:0];
      if (cfg_wr) begin
        en_q   <= wr_data[0];
        pol_q  <= wr_data[1];
        hyst_q <= wr_data[4:3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_q     <= Z_INSIDE;
      crit_hit_q <= 1'b0;
      hold_q     <= HCW'(HOLD);
    end else begin
      if (compare) begin
        zone_q     <= zone_nx;
        crit_hit_q <= crit_nx;
      end
      if (win_wr)
        hold_q <= HCW'(HOLD);
      else if (conv_done && hold_q != '0)
        hold_q <= hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win_evt_q <= 1'b0;
    else if (crossing && en_q)
      win_evt_q <= 1'b1;
    else if (cfg_wr && wr_data[2])
      win_evt_q <= 1'b0;
  end

  wire active = en_q && (win_evt_q || crit_hit_q);
  assign event_pin     = pol_q ? active : !active;
  assign event_pull_en = !event_pin;
endmodule

module temp_event_chk #(
  parameter int HCW = 1,
  parameter int HOLD = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_done,
  input logic           cfg_wr,
  input logic           win_wr,
  input logic           clr_bit,
  input logic [HCW-1:0] hold_q,
  input logic [1:0]     zone_q,
  input logic           crit_hit_q,
  input logic           win_evt_q,
  input logic           en_q,
  input logic           pol_q,
  input logic           event_pin
);
  assert_hold_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && hold_q != '0 |=> $stable(zone_q) && $stable(crit_hit_q));

  assert_hold_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr |=> hold_q == HCW'(HOLD));

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(zone_q) && $stable(crit_hit_q));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && clr_bit && !conv_done |=> !win_evt_q);

  assert_crit_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && crit_hit_q |-> event_pin == pol_q);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> event_pin == !pol_q);
endmodule

bind temp_event_gen temp_event_chk #(.HCW(HCW), .HOLD(HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .cfg_wr(cfg_wr),
  .win_wr(win_wr), .clr_bit(wr_data[2]), .hold_q(hold_q), .zone_q(zone_q),
  .crit_hit_q(crit_hit_q), .win_evt_q(win_evt_q), .en_q(en_q),
  .pol_q(pol_q), .event_pin(event_pin)
);

// File: tb/tb_temp_event_gen.sv
`timescale 1ns/100ps
module tb_temp_event_gen;
  logic clk = 0, rst_n = 0, wr_en = 0, conv_done = 0;
  logic [7:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [10:0] conv_temp = 0;
  logic event_pin, event_pull_en;
  int checks = 0, fails = 0;
  bit pol = 0, done = 0;

  typedef struct { bit act; bit pol; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  temp_event_gen dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data,
                      .conv_done, .conv_temp, .event_pin, .event_pull_en);

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 8'(a); wr_data = 16'(d);
    @(negedge clk); wr_en = 0;
    if (a == 1) pol = d[1];
  endtask

  task automatic samp(input int t);
    @(negedge clk); conv_done = 1; conv_temp = 11'(t);
    @(negedge clk); conv_done = 0;
  endtask

  task automatic both(input int d, input int t);
    @(negedge clk); wr_en = 1; wr_addr = 8'h01; wr_data = 16'(d);
    conv_done = 1; conv_temp = 11'(t);
    @(negedge clk); wr_en = 0; conv_done = 0;
    pol = d[1];
  endtask

  task automatic expect_act(input bit a, input string tag);
    item_t it;
    it.act = a; it.pol = pol; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0) begin
        item_t it;
        bit ep;
        it = q.pop_front();
        ep = it.pol ? it.act : !it.act;
        checks++;
        if (event_pin !== ep || event_pull_en !== !ep) begin
          fails++;
          $display("FAIL %s: pin=%b pull=%b expected pin=%b pull=%b",
                   it.tag, event_pin, event_pull_en, ep, !ep);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_act(0, "R1 reset inactive");
    wr(2, 320); wr(3, 40); wr(4, 380); wr(1, 16'h01);
    expect_act(0, "R2 config write alone");
    samp(400);  expect_act(0, "R7 first sample after limit write skipped");
    samp(100);  expect_act(0, "R3 inside, no crossing");
    samp(330);  expect_act(1, "R3 crossing above upper");
    wr(1, 16'h05); expect_act(0, "R6 release clears window event");
    samp(320);  expect_act(1, "R10 back inside at t==upper");
    wr(1, 16'h05); expect_act(0, "R6 release");
    wr(1, 16'h11);
    samp(38);   expect_act(0, "R4 below lower within hysteresis");
    samp(27);   expect_act(1, "R4 below lower minus hysteresis");
    wr(1, 16'h15); expect_act(0, "R6 release");
    samp(39);   expect_act(0, "R4 still below");
    samp(40);   expect_act(1, "R4 enter at t==lower");
    wr(1, 16'h15); expect_act(0, "R6 release");
    samp(380);  expect_act(1, "R5 critical reached");
    wr(1, 16'h15); expect_act(1, "R5 release ignored while critical");
    samp(372);  expect_act(1, "R5 critical held by hysteresis");
    wr(1, 16'h15); expect_act(1, "R5 release still ignored");
    samp(367);  expect_act(0, "R5 critical released below crit-H");
    both(16'h15, 100); expect_act(1, "R6 crossing wins over same-edge release");
    wr(1, 16'h15); expect_act(0, "R6 release after overlap");
    wr(1, 16'h10);
    samp(330);  expect_act(0, "R8 disabled crossing not shown");
    wr(1, 16'h11); expect_act(0, "R8 crossing while disabled not latched");
    wr(1, 16'h13);
    samp(100);  expect_act(1, "R9 active-high event");
    wr(1, 16'h17); expect_act(0, "R9 active-high inactive level");
    wr(7, 0);
    samp(330);  expect_act(1, "R2 unmapped write ignored, no holdoff");
    wr(1, 16'h17); expect_act(0, "R6 release");
    wr(2, 320);
    samp(100);  expect_act(0, "R7 holdoff after upper write");
    samp(100);  expect_act(1, "R7 compare resumes");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule